// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, a pixel clock and the coordinate of the pixel being shown. Software programs the geometry through a simple register write port. Every width, porch and size field holds its count less one. A run bit starts and stops the raster.

The pixel clock comes from the source clock through a programmable divider. When the ratio is one, the divider is bypassed and the source clock is forwarded unchanged. Each of the four timing outputs has its own polarity inversion bit. A pending interrupt is raised at a chosen line boundary of the frame, such as the start of the vertical front porch. Software clears it by writing a one.

Pixel data is produced elsewhere. A downstream fetch or pattern unit uses `pix_x`, `pix_y` and `de` to know which pixel to present.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line is, in order, active pixels, front porch, sync and back porch. Each length is its field plus one. The register at address 1 holds front porch in bits [7:0], sync in [15:8] and back porch in [23:16]. The active width is in bits [11:0] of address 3. `hsync` is active for the sync pixels only.
- R2: A frame is, in order, active lines, front porch lines, sync lines and back porch lines. Each length is its field plus one. The register at address 2 uses the same field layout as address 1. The active height is in bits [27:16] of address 3. `vsync` is active for the sync lines only.
- R3: `de` is active only when both the pixel and the line are in their active regions. At those times `pix_x` and `pix_y` give the column and row from zero. At all other times both are zero.
- R4: Control register (address 0) bits [15:8] hold the divide ratio less one, so the ratio can be up to 256. When the ratio N is above one, the raster advances one pixel every N source cycles. `pix_clk` is high for the first floor(N/2) source cycles of each pixel.
- R5: When the divide field is zero, the raster advances every source cycle and `pix_clk` follows the source clock.
- R6: Control bits 4, 5, 6 and 7 invert `vsync`, `hsync`, `de` and `pix_clk` respectively.
- R7: Control bits [2:1] choose the interrupt point. 0 means none. 1 means the first pixel of the first vertical front porch line. 2 means the first sync line. 3 means the first back porch line. `irq` is seen high from that pixel on.
- R8: Writing address 4 with bit 0 set clears `irq`. Writing it with bit 0 clear leaves `irq` unchanged.
- R9: Control bit 0 is the run enable. While it is clear, syncs and `de` are at their inactive levels, the coordinates are zero, a divided `pix_clk` stays at its inactive level, and the raster returns to the first active pixel. After the enable write, the first pixel occupies the next source cycle.
- R10: After reset, all registers are zero: the raster is stopped, no output is inverted, the interrupt is clear and the divider is in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 horizontal, 2 vertical, 3 size, 4 status) |
| wr_data | input | 32 | Register write data |
| pix_clk | output | 1 | Pixel clock after polarity |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_x | output | COORD_W | Active column, zero outside active area |
| pix_y | output | COORD_W | Active row, zero outside active area |
| irq | output | 1 | Frame interrupt pending |

## Verification
The in-RTL checks on counter bounds and phase order assume that geometry and divider fields are written only while the run bit is clear. A change while running could leave a counter beyond a newly shortened phase. The stimulus therefore stops the raster before every reconfiguration and restarts it only after all fields are written. Register writes are single-cycle strobes driven away from the clock edge. The geometry, inversion and interrupt choices come from a table that includes the all-minimum case.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_HTIME  = 3'd1;
  localparam logic [2:0] A_VTIME  = 3'd2;
  localparam logic [2:0] A_SIZE   = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;

  typedef struct packed {
    logic pclk;
    logic de;
    logic hs;
    logic vs;
  } inv_t;

endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int COORD_W = 12,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic               run,
  output logic [1:0]         irq_sel,
  output inv_t               inv,
  output logic [DIV_W-1:0]   div_m1,
  output logic [PORCH_W-1:0] h_fp,
  output logic [PORCH_W-1:0] h_sy,
  output logic [PORCH_W-1:0] h_bp,
  output logic [PORCH_W-1:0] v_fp,
  output logic [PORCH_W-1:0] v_sy,
  output logic [PORCH_W-1:0] v_bp,
  output logic [COORD_W-1:0] h_act,
  output logic [COORD_W-1:0] v_act,
  output logic               clr_irq
);

  logic               run_d;
  logic [1:0]         sel_d;
  inv_t               inv_d;
  logic [DIV_W-1:0]   div_d;
  logic [PORCH_W-1:0] hfp_d, hsy_d, hbp_d, vfp_d, vsy_d, vbp_d;
  logic [COORD_W-1:0] hact_d, vact_d;
  logic               unused_bits;

  assign unused_bits = ^wr_data;

  always_comb begin
    run_d  = run;
    sel_d  = irq_sel;
    inv_d  = inv;
    div_d  = div_m1;
    hfp_d  = h_fp;
    hsy_d  = h_sy;
    hbp_d  = h_bp;
    vfp_d  = v_fp;
    vsy_d  = v_sy;
    vbp_d  = v_bp;
    hact_d = h_act;
    vact_d = v_act;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run_d = wr_data[0];
          sel_d = wr_data[2:1];
          inv_d = inv_t'(wr_data[7:4]);
          div_d = wr_data[8 +: DIV_W];
        end
        A_HTIME: begin
          hfp_d = wr_data[0 +: PORCH_W];
          hsy_d = wr_data[8 +: PORCH_W];
          hbp_d = wr_data[16 +: PORCH_W];
        end
        A_VTIME: begin
          vfp_d = wr_data[0 +: PORCH_W];
          vsy_d = wr_data[8 +: PORCH_W];
          vbp_d = wr_data[16 +: PORCH_W];
        end
        A_SIZE: begin
          hact_d = wr_data[0 +: COORD_W];
          vact_d = wr_data[16 +: COORD_W];
        end
        default: ;
      endcase
    end
  end

  assign clr_irq = wr_en && (wr_addr == A_STATUS) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      irq_sel <= 2'd0;
      inv     <= '0;
      div_m1  <= '0;
      h_fp    <= '0;
      h_sy    <= '0;
      h_bp    <= '0;
      v_fp    <= '0;
      v_sy    <= '0;
      v_bp    <= '0;
      h_act   <= '0;
      v_act   <= '0;
    end else if (wr_en) begin
      run     <= run_d;
      irq_sel <= sel_d;
      inv     <= inv_d;
      div_m1  <= div_d;
      h_fp    <= hfp_d;
      h_sy    <= hsy_d;
      h_bp    <= hbp_d;
      v_fp    <= vfp_d;
      v_sy    <= vsy_d;
      v_bp    <= vbp_d;
      h_act   <= hact_d;
      v_act   <= vact_d;
    end
  end

endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio_m1,
  output logic             pix_ce,
  output logic             pix_lvl,
  output logic             bypass
);

  localparam int RW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [RW-1:0]    half;
  logic             cnt_en;

  assign bypass = (ratio_m1 == '0);
  assign half   = ({1'b0, ratio_m1} + RW'(1)) >> 1;
  assign pix_ce = run && (cnt_q == ratio_m1);
  assign pix_lvl = run && ({1'b0, cnt_q} < half);

  always_comb begin
    if (!run || pix_ce) cnt_d = '0;
    else                cnt_d = cnt_q + DIV_W'(1);
  end

  assign cnt_en = run || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: with a ratio above one, two pixel strobes are never adjacent
  a_r4_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && ratio_m1 != '0) |=> (!pix_ce || ratio_m1 == '0));

endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int ACT_W   = 12,
  parameter int PORCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [ACT_W-1:0]   act_last,
  input  logic [PORCH_W-1:0] fp_last,
  input  logic [PORCH_W-1:0] sy_last,
  input  logic [PORCH_W-1:0] bp_last,
  output phase_e             phase,
  output logic [ACT_W-1:0]   cnt,
  output logic [3:0]         enter,
  output logic               wrap
);

  phase_e           phase_q, phase_d, nxt_ph;
  logic [ACT_W-1:0] cnt_q, cnt_d, cur_last;
  logic             at_last, upd;

  always_comb begin
    case (phase_q)
      PH_ACT:  cur_last = act_last;
      PH_FP:   cur_last = ACT_W'(fp_last);
      PH_SYNC: cur_last = ACT_W'(sy_last);
      default: cur_last = ACT_W'(bp_last);
    endcase
  end

  assign at_last = (cnt_q == cur_last);
  assign nxt_ph  = phase_e'(phase_q + 2'd1);
  assign wrap    = step && at_last && (phase_q == PH_BP);
  assign upd     = clear || step;

  always_comb begin
    enter = 4'b0000;
    if (step && at_last && !clear) enter[nxt_ph] = 1'b1;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (clear) begin
      phase_d = PH_ACT;
      cnt_d   = '0;
    end else if (step) begin
      if (at_last) begin
        phase_d = nxt_ph;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + ACT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACT;
      cnt_q   <= '0;
    end else if (upd) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;

  // R1 and its vertical twin: the counter never passes its phase length
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cur_last);

  // R1: phases advance only one step at a time, in raster order
  a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (phase_q == $past(phase_q) ||
                phase_q == phase_e'($past(phase_q) + 2'd1)));

endmodule

// File: rtl/lcd_tg_irq.sv
module lcd_tg_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic [3:0] v_enter,
  input  logic       clr,
  output logic       pend
);

  logic set, pend_d;

  assign set = (sel != 2'd0) && v_enter[sel];

  always_comb begin
    if (set)      pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
    else          pend_d = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // R7: a pending flag only appears when an interrupt point is chosen
  a_r7_rise_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(sel) != 2'd0));

  // R8: a one written to the status register clears the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int COORD_W = 12,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic               pix_clk,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y,
  output logic               irq
);

  logic               run, clr_irq, pix_ce, pix_lvl, bypass;
  logic [1:0]         irq_sel;
  inv_t               inv;
  logic [DIV_W-1:0]   div_m1;
  logic [PORCH_W-1:0] h_fp, h_sy, h_bp, v_fp, v_sy, v_bp;
  logic [COORD_W-1:0] h_act, v_act, h_cnt, v_cnt;
  phase_e             h_ph, v_ph;
  logic [3:0]         h_enter, v_enter;
  logic               h_wrap, v_wrap;
  logic               unused_axis;
  logic               de_raw, hs_raw, vs_raw, pclk_raw;

  assign unused_axis = ^{h_enter, v_wrap};

  lcd_tg_regs #(.PORCH_W(PORCH_W), .COORD_W(COORD_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .irq_sel(irq_sel), .inv(inv), .div_m1(div_m1),
    .h_fp(h_fp), .h_sy(h_sy), .h_bp(h_bp), .v_fp(v_fp), .v_sy(v_sy), .v_bp(v_bp),
    .h_act(h_act), .v_act(v_act), .clr_irq(clr_irq)
  );

  lcd_tg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .ratio_m1(div_m1),
    .pix_ce(pix_ce), .pix_lvl(pix_lvl), .bypass(bypass)
  );

  lcd_tg_axis #(.ACT_W(COORD_W), .PORCH_W(PORCH_W)) u_hax (
    .clk(clk), .rst_n(rst_n), .clear(!run), .step(pix_ce),
    .act_last(h_act), .fp_last(h_fp), .sy_last(h_sy), .bp_last(h_bp),
    .phase(h_ph), .cnt(h_cnt), .enter(h_enter), .wrap(h_wrap)
  );

  lcd_tg_axis #(.ACT_W(COORD_W), .PORCH_W(PORCH_W)) u_vax (
    .clk(clk), .rst_n(rst_n), .clear(!run), .step(h_wrap),
    .act_last(v_act), .fp_last(v_fp), .sy_last(v_sy), .bp_last(v_bp),
    .phase(v_ph), .cnt(v_cnt), .enter(v_enter), .wrap(v_wrap)
  );

  lcd_tg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sel(irq_sel), .v_enter(v_enter),
    .clr(clr_irq), .pend(irq)
  );

  always_comb begin
    de_raw   = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
    hs_raw   = run && (h_ph == PH_SYNC);
    vs_raw   = run && (v_ph == PH_SYNC);
    pclk_raw = bypass ? clk : pix_lvl;
    de       = de_raw ^ inv.de;
    hsync    = hs_raw ^ inv.hs;
    vsync    = vs_raw ^ inv.vs;
    pix_clk  = pclk_raw ^ inv.pclk;
    pix_x    = de_raw ? h_cnt : '0;
    pix_y    = de_raw ? v_cnt : '0;
  end

  // R9: a stopped raster is back at the first active pixel one cycle later
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (h_ph == PH_ACT && h_cnt == '0 && v_ph == PH_ACT && v_cnt == '0));

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pix_clk, hsync, vsync, de, irq;
  logic [11:0] pix_x, pix_y;

  int errors = 0;
  int checks = 0;

  // columns: hact,hfp,hsync,hbp,vact,vfp,vsync,vbp (all minus one), inversion, irq point
  localparam int ROWS [4][10] = '{
    '{5, 1, 2, 0, 3, 0, 1, 1, 0,  1},
    '{0, 0, 0, 0, 0, 0, 0, 0, 15, 2},
    '{4, 2, 0, 1, 2, 1, 0, 2, 5,  3},
    '{3, 0, 1, 3, 1, 2, 1, 0, 10, 0}
  };

  always #5 clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  int ha, hf, hs, hb, va, vf, vs, vb, inv, sel, ht, vt, frame, thresh;
  int h, l, ex, ey, act, exp;
  bit e_de, e_hs, e_vs, t_bad, i_bad, c_bad;
  int t_a, t_e, i_a, i_e, c_a, c_e, ones;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R10: reset state, divider in bypass so pix_clk matches the low clock
    check({hsync, vsync, de, irq, pix_clk} == 5'b0 && pix_x == 0 && pix_y == 0,
          "R10 reset outputs", int'({hsync, vsync, de, irq, pix_clk}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) begin
      ha = ROWS[r][0] + 1; hf = ROWS[r][1] + 1; hs = ROWS[r][2] + 1; hb = ROWS[r][3] + 1;
      va = ROWS[r][4] + 1; vf = ROWS[r][5] + 1; vs = ROWS[r][6] + 1; vb = ROWS[r][7] + 1;
      inv = ROWS[r][8]; sel = ROWS[r][9];
      ht = ha + hf + hs + hb; vt = va + vf + vs + vb; frame = ht * vt;
      thresh = (sel == 1) ? va * ht : (sel == 2) ? (va + vf) * ht :
               (sel == 3) ? (va + vf + vs) * ht : 1 << 30;
      wr(3'd0, 32'd0);
      wr(3'd1, 32'(ROWS[r][1] | (ROWS[r][2] << 8) | (ROWS[r][3] << 16)));
      wr(3'd2, 32'(ROWS[r][5] | (ROWS[r][6] << 8) | (ROWS[r][7] << 16)));
      wr(3'd3, 32'(ROWS[r][0] | (ROWS[r][4] << 16)));
      wr(3'd4, 32'd1);
      wr(3'd0, 32'(1 | (sel << 1) | (inv << 4)));
      t_bad = 0; i_bad = 0; c_bad = 0;
      t_a = 0; t_e = 0; i_a = 0; i_e = 0; c_a = 0; c_e = 0;
      for (int p = 0; p < 2 * frame; p++) begin
        h = p % ht; l = (p / ht) % vt;
        e_de = (h < ha) && (l < va);
        e_hs = (h >= ha + hf) && (h < ha + hf + hs);
        e_vs = (l >= va + vf) && (l < va + vf + vs);
        ex = e_de ? h : 0; ey = e_de ? l : 0;
        exp = int'({5'd0, 12'(ex), 12'(ey), e_hs ^ inv[1], e_vs ^ inv[0], e_de ^ inv[2]});
        act = int'({5'd0, pix_x, pix_y, hsync, vsync, de});
        if (act != exp && !t_bad) begin t_bad = 1; t_a = act; t_e = exp; end
        if (int'(irq) != int'(p >= thresh) && !i_bad) begin
          i_bad = 1; i_a = int'(irq); i_e = int'(p >= thresh);
        end
        if (int'(pix_clk) != inv[3] && !c_bad) begin
          c_bad = 1; c_a = int'(pix_clk); c_e = inv[3];
        end
        @(negedge clk);
      end
      // R1 R2 R3 R6 R9: raster order, lengths, de window, coordinates, polarity
      check(!t_bad, "R1/R2/R3/R6/R9 raster vector", t_a, t_e);
      // R7: interrupt point
      check(!i_bad, "R7 irq point", i_a, i_e);
      // R5 R6: bypassed clock follows source, sampled while the source is low
      check(!c_bad, "R5/R6 bypass pix_clk", c_a, c_e);

      if (r == 0) begin
        wr(3'd0, 32'd0);
        check({hsync, vsync, de} == 3'b0 && pix_x == 0 && pix_y == 0,
              "R9 stopped outputs", int'({hsync, vsync, de}), 0);
        wr(3'd4, 32'd0);
        check(irq == 1'b1, "R8 write zero keeps irq", int'(irq), 1);
        wr(3'd4, 32'd1);
        check(irq == 1'b0, "R8 write one clears irq", int'(irq), 0);
      end
    end

    // R4: divide by four, then by three with inverted pixel clock (R6)
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h0003_003F);
    wr(3'd0, 32'h0000_0301);
    c_bad = 0; t_bad = 0; ones = 0;
    for (int n = 0; n < 16; n++) begin
      if (pix_clk) ones++;
      if (int'(pix_clk) != int'((n % 4) < 2)) c_bad = 1;
      if (int'(pix_x) != n / 4 || !de) t_bad = 1;
      @(negedge clk);
    end
    check(!c_bad && ones == 8, "R4 divide-by-4 pix_clk high count", ones, 8);
    check(!t_bad, "R4 divide-by-4 pixel advance", int'(pix_x), 3);

    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0000_0281);
    c_bad = 0; t_bad = 0;
    for (int n = 0; n < 12; n++) begin
      if (int'(pix_clk) != int'(!((n % 3) < 1))) c_bad = 1;
      if (int'(pix_x) != n / 3) t_bad = 1;
      @(negedge clk);
    end
    check(!c_bad, "R4/R6 divide-by-3 inverted pix_clk", int'(pix_clk), 0);
    check(!t_bad, "R4 divide-by-3 pixel advance", int'(pix_x), 3);

    // R9: a stopped divider keeps pix_clk at its inactive level
    wr(3'd0, 32'h0000_0300);
    ones = 0;
    for (int n = 0; n < 8; n++) begin
      if (pix_clk) ones++;
      @(negedge clk);
    end
    check(ones == 0, "R9 stopped divider pix_clk", ones, 0);

    // R4: largest ratio, 256 source cycles per pixel
    wr(3'd0, 32'h0000_FF01);
    for (int n = 0; n <= 256; n++) begin
      if (n == 0)   check(pix_clk == 1'b1, "R4 ratio 256 first half high", int'(pix_clk), 1);
      if (n == 255) check(pix_x == 12'd0, "R4 ratio 256 last cycle of pixel 0", int'(pix_x), 0);
      if (n == 256) check(pix_x == 12'd1, "R4 ratio 256 pixel 1", int'(pix_x), 1);
      @(negedge clk);
    end

    summary();
  end

endmodule